// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port Controller

This block is a register-mapped general-purpose pin controller built from several ports of eight pins each. Each pin has a two-bit mode. The mode hands the pin to its alternate peripheral, makes it an output, or makes it an input with or without a pull-up. The block does not contain the pad drivers, the pull-up devices or the peripherals. It produces only their per-pin control signals.

Every pin input passes through a multi-flop synchroniser. An input-mode pin whose synchronised level changes in the selected direction sets a sticky status bit. Software clears that bit by writing a one to it. Each pin can be masked on its own. The unmasked status bits of every port are ORed onto one interrupt line.

A simple word bus reaches the registers. Writes take effect at the clock edge, and reads are combinational from the address. Address bits [5:4] pick one of four register banks. Bits [3:1] pick the port, so ports sit two bytes apart, and bit 0 is ignored.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every pin is in mode 3 (config registers read 0xFFFF), every interrupt is masked with falling-edge select (interrupt control reads 0x00FF), status reads 0, all output latches are 0, and irq, pin_oe, pin_pullup and pin_alt are all low.
- R2: Address decoding works as follows. bus_addr[5:4] selects the bank: 0 configuration, 1 data, 2 interrupt control, 3 status. bus_addr[3:1] selects the port, and bus_addr[0] is ignored. Port indices at or above NUM_PORTS read as 0 and ignore writes. Pin p of port k is bit k*8+p of every pin vector.
- R3: Configuration bits [2p+1:2p] set the mode of pin p. Mode 0 raises pin_alt, mode 1 raises pin_oe, mode 2 raises pin_pullup, and mode 3 raises none of them. At most one of these three is high for a pin.
- R4: Data-bank writes load the output latches that drive pin_out. A data-bank read returns the synchronised pin levels in bits [7:0], with zeros above them. A change on pin_in appears in that read after two clock edges, not after one.
- R5: Interrupt control bit p+8 selects the edge for pin p: 1 for rising, 0 for falling. A matching edge on a pin in mode 2 or 3 sets status bit p on the third clock edge after the pin changes. Edges in the other direction, and edges on pins in mode 0 or 1, set nothing.
- R6: Status bits are sticky. Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged. A status bit never clears without a status-bank write.
- R7: When an edge and a clearing write reach the same status bit at the same clock edge, the bit stays set.
- R8: irq is high exactly when some status bit has its mask bit (interrupt control bit p) at 0. Masked pins still latch status.
- R9: The block records no edges while the synchroniser refills after reset. Status stays 0 through the first SYNC_STAGES+1 clock edges after reset, even if a pin was high during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address: bank, port, ignored LSB |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| pin_in | input | 40 | Pad input levels, asynchronous |
| pin_out | output | 40 | Output latch values |
| pin_oe | output | 40 | Output drive enable (mode 1) |
| pin_pullup | output | 40 | Pull-up enable (mode 2) |
| pin_alt | output | 40 | Alternate function select (mode 0) |
| irq | output | 1 | Combined interrupt request |

## Verification
Several properties are checked on every cycle. A pin never holds two roles at once. A status bit rises only for a pin that was in an input mode. A status bit falls only after a status-bank write. irq never rises without a latched status bit and stays low while every pin is masked. Status stays empty until the synchroniser has refilled after reset. Other behaviour can be shown only by the bench's scenarios: the exact edge-to-status latency, edge-direction selection, the set-over-clear collision, readback of out-of-range ports, and the mapping of the last port's pins.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
   typedef enum logic [1:0] {
      MODE_ALT   = 2'd0,
      MODE_OUT   = 2'd1,
      MODE_IN_PU = 2'd2,
      MODE_IN    = 2'd3
   } pin_mode_e;

   typedef enum logic [1:0] {
      BANK_CFG  = 2'd0,
      BANK_DATA = 2'd1,
      BANK_ICTL = 2'd2,
      BANK_STAT = 2'd3
   } bank_e;

   localparam int unsigned MODE_W     = 2;
   localparam int unsigned ADDR_W     = 6;
   localparam int unsigned PORT_IDX_W = 3;
endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   logic [STAGES-1:0][WIDTH-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else begin
         stage_q[0] <= d_async;
         for (int s = 1; s < STAGES; s++) begin
            stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
   import gpio_edge_pkg::*;
#(
   parameter int unsigned PINS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              edge_arm,
   input  logic              wr_cfg,
   input  logic              wr_data,
   input  logic              wr_ictl,
   input  logic              wr_stat,
   input  logic [2*PINS-1:0] wdata,
   input  logic [PINS-1:0]   pin_sync,
   output logic [2*PINS-1:0] cfg_q,
   output logic [PINS-1:0]   out_q,
   output logic [2*PINS-1:0] ictl_q,
   output logic [PINS-1:0]   stat_q,
   output logic [PINS-1:0]   pin_oe,
   output logic [PINS-1:0]   pin_pullup,
   output logic [PINS-1:0]   pin_alt,
   output logic              irq_req
);
   logic [PINS-1:0] prev_q;
   logic [PINS-1:0] edge_hit;
   logic [PINS-1:0] clr_mask;

   // Per-pin mode decode and edge qualification
   for (genvar p = 0; p < PINS; p++) begin : g_pin
      pin_mode_e mode;
      logic      is_input;
      logic      rise;
      logic      fall;

      assign mode          = pin_mode_e'(cfg_q[MODE_W*p +: MODE_W]);
      assign pin_alt[p]    = (mode == MODE_ALT);
      assign pin_oe[p]     = (mode == MODE_OUT);
      assign pin_pullup[p] = (mode == MODE_IN_PU);
      assign is_input      = (mode == MODE_IN) || (mode == MODE_IN_PU);
      assign rise          = pin_sync[p] & ~prev_q[p];
      assign fall          = ~pin_sync[p] & prev_q[p];
      assign edge_hit[p]   = edge_arm & is_input & (ictl_q[PINS+p] ? rise : fall);
   end

   assign clr_mask = wr_stat ? wdata[PINS-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '1;
         out_q  <= '0;
         ictl_q <= {{PINS{1'b0}}, {PINS{1'b1}}};
         stat_q <= '0;
         prev_q <= '0;
      end else begin
         if (wr_cfg)  cfg_q  <= wdata;
         if (wr_data) out_q  <= wdata[PINS-1:0];
         if (wr_ictl) ictl_q <= wdata;
         // set term ORed last: an edge beats a same-cycle clear
         stat_q <= (stat_q & ~clr_mask) | edge_hit;
         prev_q <= pin_sync;
      end
   end

   assign irq_req = |(stat_q & ~ictl_q[PINS-1:0]);
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
   import gpio_edge_pkg::*;
#(
   parameter int unsigned NUM_PORTS     = 5,
   parameter int unsigned PINS_PER_PORT = 8,
   parameter int unsigned SYNC_STAGES   = 2,
   localparam int unsigned REG_W        = 2 * PINS_PER_PORT,
   localparam int unsigned NUM_PINS     = NUM_PORTS * PINS_PER_PORT
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [REG_W-1:0]    bus_wdata,
   output logic [REG_W-1:0]    bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic [NUM_PINS-1:0] pin_pullup,
   output logic [NUM_PINS-1:0] pin_alt,
   output logic                irq
);
   // Elaboration-time parameter checks
   if (PINS_PER_PORT != 8) begin : g_bad_pins
      $error("PINS_PER_PORT must be 8: mask and edge bytes share one 16-bit register");
   end
   if (NUM_PORTS < 1 || NUM_PORTS > (1 << PORT_IDX_W)) begin : g_bad_ports
      $error("NUM_PORTS must fit the port index field");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   bank_e                       bank;
   logic [PORT_IDX_W-1:0]       port_sel;
   logic                        unused_addr_lsb;
   logic [NUM_PINS-1:0]         pin_sync_all;
   logic [SYNC_STAGES:0]        arm_q;
   logic [NUM_PORTS*REG_W-1:0]  cfg_flat;
   logic [NUM_PORTS*REG_W-1:0]  ictl_flat;
   logic [NUM_PINS-1:0]         stat_all;
   logic [NUM_PORTS-1:0]        irq_vec;

   assign bank            = bank_e'(bus_addr[5:4]);
   assign port_sel        = bus_addr[3:1];
   assign unused_addr_lsb = bus_addr[0];

   gpio_edge_sync #(
      .WIDTH (NUM_PINS),
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_async(pin_in),
      .q_sync (pin_sync_all)
   );

   // Edge detection stays disarmed until the synchroniser and history refill
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) arm_q <= '0;
      else        arm_q <= {arm_q[SYNC_STAGES-1:0], 1'b1};
   end

   for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
      logic sel;
      assign sel = bus_we && (port_sel == PORT_IDX_W'(i));

      gpio_edge_port #(
         .PINS(PINS_PER_PORT)
      ) u_port (
         .clk       (clk),
         .rst_n     (rst_n),
         .edge_arm  (arm_q[SYNC_STAGES]),
         .wr_cfg    (sel && (bank == BANK_CFG)),
         .wr_data   (sel && (bank == BANK_DATA)),
         .wr_ictl   (sel && (bank == BANK_ICTL)),
         .wr_stat   (sel && (bank == BANK_STAT)),
         .wdata     (bus_wdata),
         .pin_sync  (pin_sync_all[i*PINS_PER_PORT +: PINS_PER_PORT]),
         .cfg_q     (cfg_flat[i*REG_W +: REG_W]),
         .out_q     (pin_out[i*PINS_PER_PORT +: PINS_PER_PORT]),
         .ictl_q    (ictl_flat[i*REG_W +: REG_W]),
         .stat_q    (stat_all[i*PINS_PER_PORT +: PINS_PER_PORT]),
         .pin_oe    (pin_oe[i*PINS_PER_PORT +: PINS_PER_PORT]),
         .pin_pullup(pin_pullup[i*PINS_PER_PORT +: PINS_PER_PORT]),
         .pin_alt   (pin_alt[i*PINS_PER_PORT +: PINS_PER_PORT]),
         .irq_req   (irq_vec[i])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_PORTS; i++) begin
         if (port_sel == PORT_IDX_W'(i)) begin
            case (bank)
               BANK_CFG:  bus_rdata = cfg_flat[i*REG_W +: REG_W];
               BANK_DATA: bus_rdata = REG_W'(pin_sync_all[i*PINS_PER_PORT +: PINS_PER_PORT]);
               BANK_ICTL: bus_rdata = ictl_flat[i*REG_W +: REG_W];
               default:   bus_rdata = REG_W'(stat_all[i*PINS_PER_PORT +: PINS_PER_PORT]);
            endcase
         end
      end
   end

   assign irq = |irq_vec;
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
   parameter int unsigned NUM_PORTS = 5,
   parameter int unsigned PINS      = 8,
   localparam int unsigned NUM_PINS = NUM_PORTS * PINS
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   bus_we,
   input logic [1:0]             bus_bank,
   input logic [2*NUM_PINS-1:0]  cfg_flat,
   input logic [2*NUM_PINS-1:0]  ictl_flat,
   input logic [NUM_PINS-1:0]    stat_all,
   input logic [NUM_PINS-1:0]    pin_oe,
   input logic [NUM_PINS-1:0]    pin_pullup,
   input logic [NUM_PINS-1:0]    pin_alt,
   input logic                   irq,
   input logic                   edge_arm
);
   logic [NUM_PINS-1:0] mask_all;
   logic                unused_chk;

   assign unused_chk = ^{cfg_flat, ictl_flat};

   for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
      assign mask_all[n] = ictl_flat[(n / PINS) * 2 * PINS + (n % PINS)];

      // R3: a pin never holds two roles at once
      a_r3_single_role: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0({pin_oe[n], pin_pullup[n], pin_alt[n]}));

      // R5: status rises only for a pin that was in an input mode
      a_r5_input_only: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(stat_all[n]) |-> $past(cfg_flat[2*n+1]));
   end

   // R6: status bits fall only after a status-bank write
   a_r6_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(stat_all) & ~stat_all)) |-> $past(bus_we && (bus_bank == 2'd3)));

   // R8: irq needs a latched status bit
   a_r8_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|stat_all));

   // R8: all pins masked keeps irq low
   a_r8_full_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_all) |-> !irq);

   // R9: nothing latched while edge detection is disarmed
   a_r9_quiet_until_armed: assert property (@(posedge clk) disable iff (!rst_n)
      !edge_arm |-> (stat_all == '0));
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(
   .NUM_PORTS(NUM_PORTS),
   .PINS     (PINS_PER_PORT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_bank  (bus_addr[5:4]),
   .cfg_flat  (cfg_flat),
   .ictl_flat (ictl_flat),
   .stat_all  (stat_all),
   .pin_oe    (pin_oe),
   .pin_pullup(pin_pullup),
   .pin_alt   (pin_alt),
   .irq       (irq),
   .edge_arm  (arm_q[SYNC_STAGES])
);

// File: tb/gpio_edge_ctrl_bench.sv
module gpio_edge_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 40;
   localparam int NV = 7;
   // {addr[5:0], write data[15:0], expected readback[15:0]}
   localparam logic [37:0] VEC [NV] = '{
      {6'h00, 16'h1234, 16'h1234},   // cfg port 0
      {6'h08, 16'hA5C3, 16'hA5C3},   // cfg port 4
      {6'h24, 16'h5AF0, 16'h5AF0},   // ictl port 2
      {6'h28, 16'hFFFF, 16'hFFFF},   // ictl port 4
      {6'h0A, 16'h1111, 16'h0000},   // cfg port 5 absent
      {6'h2E, 16'h7777, 16'h0000},   // ictl port 7 absent
      {6'h03, 16'h0F0F, 16'h0F0F}    // cfg port 1, odd byte address
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_we = 1'b0;
   logic [5:0]    bus_addr = '0;
   logic [15:0]   bus_wdata = '0;
   logic [15:0]   bus_rdata;
   logic [NP-1:0] ext_pins = '0;
   logic [NP-1:0] pin_in;
   logic [NP-1:0] pin_out, pin_oe, pin_pullup, pin_alt;
   logic          irq;
   int            n_checks = 0;
   int            n_fail = 0;
   bit            done = 1'b0;
   logic [15:0]   rd;

   always #(CLK_PERIOD/2) clk = ~clk;

   // driven pins loop back to the pad input
   assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_pins);

   gpio_edge_ctrl u_gpio_edge_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .pin_pullup(pin_pullup),
      .pin_alt(pin_alt), .irq(irq)
   );

   task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [5:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [5:0] a, output logic [15:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();

      // R2: table walk of register writes and readbacks
      for (int i = 0; i < NV; i++) begin
         bus_write(VEC[i][37:32], VEC[i][31:16]);
         bus_read(VEC[i][37:32], rd);
         check($sformatf("R2 vec%0d", i), 40'(rd), 40'(VEC[i][15:0]));
      end

      do_reset();
      // R1: reset state
      bus_read(6'h06, rd); check("R1 cfg", 40'(rd), 40'hFFFF);
      bus_read(6'h20, rd); check("R1 ictl", 40'(rd), 40'h00FF);
      bus_read(6'h30, rd); check("R1 status", 40'(rd), 40'h0);
      bus_read(6'h10, rd); check("R1 data", 40'(rd), 40'h0);
      check("R1 irq", 40'(irq), 40'h0);
      check("R1 roles", 40'(pin_oe | pin_pullup | pin_alt), 40'h0);
      check("R1 out", pin_out, 40'h0);

      // R3: pins 0..3 in modes 0..3
      bus_write(6'h00, 16'hFFE4);
      check("R3 alt", pin_alt, 40'h01);
      check("R3 oe", pin_oe, 40'h02);
      check("R3 pullup", pin_pullup, 40'h04);

      // R4: output latch and synchronised readback with latency
      bus_write(6'h10, 16'h0002);
      check("R4 pin_out", pin_out, 40'h02);
      idle(2);
      ext_pins[3] = 1'b1;
      idle(1);
      bus_read(6'h10, rd); check("R4 one edge", 40'(rd), 40'h0002);
      idle(1);
      bus_read(6'h10, rd); check("R4 two edges", 40'(rd), 40'h000A);

      // R5: rising edge ignored under falling select, falling edge latency
      idle(3);
      bus_read(6'h30, rd); check("R5 wrong edge", 40'(rd), 40'h0);
      ext_pins[3] = 1'b0;
      idle(2);
      bus_read(6'h30, rd); check("R5 two edges", 40'(rd), 40'h0);
      idle(1);
      bus_read(6'h30, rd); check("R5 three edges", 40'(rd), 40'h0008);
      check("R8 masked irq", 40'(irq), 40'h0);

      // R8: unmask pin 3
      bus_write(6'h20, 16'h00F7);
      check("R8 unmasked irq", 40'(irq), 40'h1);

      // R6: write-one-to-clear
      bus_write(6'h30, 16'h0000);
      bus_read(6'h30, rd); check("R6 zero write", 40'(rd), 40'h0008);
      bus_write(6'h30, 16'h00F7);
      bus_read(6'h30, rd); check("R6 other bits", 40'(rd), 40'h0008);
      bus_write(6'h30, 16'h0008);
      bus_read(6'h30, rd); check("R6 cleared", 40'(rd), 40'h0);
      check("R6 irq low", 40'(irq), 40'h0);

      // R5: rising select
      bus_write(6'h20, 16'h08F7);
      ext_pins[3] = 1'b1;
      idle(3);
      bus_read(6'h30, rd); check("R5 rising", 40'(rd), 40'h0008);
      bus_write(6'h30, 16'h0008);

      // R5: output and alternate pins latch nothing
      bus_write(6'h10, 16'h0000);
      ext_pins[0] = 1'b1;
      idle(4);
      ext_pins[0] = 1'b0;
      idle(4);
      bus_read(6'h30, rd); check("R5 non-input pins", 40'(rd), 40'h0);

      // R7: edge and clear at the same clock edge
      ext_pins[3] = 1'b0;
      idle(4);
      ext_pins[3] = 1'b1;
      idle(3);
      bus_read(6'h30, rd); check("R7 preset", 40'(rd), 40'h0008);
      ext_pins[3] = 1'b0;
      idle(4);
      ext_pins[3] = 1'b1;
      idle(1);
      bus_write(6'h30, 16'h0008);
      bus_read(6'h30, rd); check("R7 set wins", 40'(rd), 40'h0008);
      bus_write(6'h30, 16'h0008);
      bus_read(6'h30, rd); check("R7 later clear", 40'(rd), 40'h0);

      // R8: masked pin still latches
      ext_pins[4] = 1'b1;
      idle(4);
      ext_pins[4] = 1'b0;
      idle(4);
      bus_read(6'h30, rd); check("R8 masked latch", 40'(rd), 40'h0010);
      check("R8 masked no irq", 40'(irq), 40'h0);
      bus_write(6'h20, 16'h08E7);
      check("R8 unmask irq", 40'(irq), 40'h1);
      bus_write(6'h30, 16'h0010);
      check("R8 cleared irq", 40'(irq), 40'h0);

      // R2: last port, pin 7 is global pin 39
      bus_write(6'h28, 16'h8000);
      ext_pins[39] = 1'b1;
      idle(4);
      bus_read(6'h38, rd); check("R2 port4 status", 40'(rd), 40'h0080);
      bus_read(6'h30, rd); check("R2 port0 status", 40'(rd), 40'h0);
      bus_read(6'h18, rd); check("R2 port4 data", 40'(rd), 40'h0080);
      check("R2 port4 irq", 40'(irq), 40'h1);

      // R9: pin high through reset, rising select set right after
      ext_pins = '0;
      ext_pins[5] = 1'b1;
      do_reset();
      bus_write(6'h20, 16'h2000);
      idle(4);
      bus_read(6'h30, rd); check("R9 no refill edge", 40'(rd), 40'h0);
      ext_pins[5] = 1'b0;
      idle(4);
      ext_pins[5] = 1'b1;
      idle(3);
      bus_read(6'h30, rd); check("R9 later edge", 40'(rd), 40'h0020);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule